// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block is a bank of ten 32-bit control registers on a simple single-beat register bus. Each register keeps 16 stored bits. A write carries its own enable mask: the upper half of the write word selects which bits of the lower half are replaced. Software can therefore change one field, such as a divider or a single reset bit, in one bus cycle. It needs no read-modify-write, and a second agent updating another field of the same register cannot race with it.

The bank sits at a fixed base address (0x140000 by default) and implements a sparse map. Three PLL control words, a PLL mode word, four clock-select words, a clock-gate word and a soft-reset word live at fixed offsets. Bit 10 of the second PLL word is read-only and reflects a live lock input from the PLL. The bank drives the stored values, and named fields decoded from them, straight to the clock and reset logic elsewhere on the chip. Every bus request receives exactly one registered response in the following cycle.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: After reset every stored bit of every register is 0, rsp_valid is low and every field output is 0.
- R2: A write to an implemented register replaces stored bit n (0..15) with write bit n only when write bit n+16 is 1. All other stored bits keep their value, so a write whose upper half is zero changes nothing.
- R3: A request accepted at a rising edge gives rsp_valid high for exactly one cycle after that edge. A read of an implemented register returns the stored 16 bits in rsp_rdata[15:0] with rsp_rdata[31:16] zero. A write response carries rsp_rdata equal to 0.
- R4: The implemented byte offsets from the base are 0x00, 0x04, 0x08 (PLL control 0..2), 0x20 (mode), 0x30, 0x34, 0x38, 0x3C (clock select 0..3), 0x40 (gate) and 0x50 (soft reset). Any other address, including a misaligned address or one outside the 256-byte window at the base, gives rsp_err=1 and rsp_rdata=0, and a write to it changes no register. rsp_err is 0 for implemented offsets.
- R5: Bit 10 of PLL control 1 ignores writes. A read of that register returns in bit 10 the value pll_lock_i had at the accepting edge.
- R6: pll_pd_o is bit 13 of PLL control 1, pll_postdiv2_o is bits [8:6] and pll_refdiv_o is bits [5:0]. pll_ctl0_o and pll_ctl2_o are the full stored words of PLL control 0 and 2.
- R7: In the soft-reset register, bit 10 drives srst_vid1x_o, bit 9 drives srst_vid4x_o, bit 8 drives srst_venc_bus_o and bit 3 drives srst_regfile_o.
- R8: vclk4x_div_o is bits [12:8] of clock select 1 and pll_mode_o is bits [2:0] of the mode register. clksel_o carries clock select 3..0 from the most significant to the least significant 16 bits, and gate_o is the gate register.
- R9: In a cycle with no request, rsp_valid stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | [31:16] bit enables, [15:0] data |
| pll_lock_i | input | 1 | Live PLL lock indication |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Address not implemented |
| pll_ctl0_o | output | 16 | PLL control 0 word |
| pll_pd_o | output | 1 | PLL power-down |
| pll_postdiv2_o | output | 3 | Second post-divider |
| pll_refdiv_o | output | 6 | Reference divider |
| pll_ctl2_o | output | 16 | PLL control 2 word |
| pll_mode_o | output | 3 | PLL mode |
| vclk4x_div_o | output | 5 | 4x video clock divider |
| clksel_o | output | 64 | Clock select 3..0 |
| gate_o | output | 16 | Clock gate word |
| srst_vid1x_o | output | 1 | Reset, 1x video domain |
| srst_vid4x_o | output | 1 | Reset, 4x video domain |
| srst_venc_bus_o | output | 1 | Reset, encoder bus side |
| srst_regfile_o | output | 1 | Reset, register file |

## Verification
The assertions assume that the request inputs are known, not X, at every rising edge outside reset, and that pll_lock_i is already synchronous to clk, so the value sampled at an edge is the one a read reports. They also assume that req_valid is low while rst_n is low. The stimulus changes every input only on the falling edge and holds req_valid low throughout reset. It moves pll_lock_i only together with a request, so the lock value at each accepting edge is known. Addresses cover every implemented offset, holes inside the window, a misaligned address and an address outside the window.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

   localparam int NREG   = 10;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;
   localparam int IDX_W  = $clog2(NREG);
   localparam int LOCK_BIT = 10;

   typedef enum logic [IDX_W-1:0] {
      IX_PLL0 = 4'd0,
      IX_PLL1 = 4'd1,
      IX_PLL2 = 4'd2,
      IX_MODE = 4'd3,
      IX_SEL0 = 4'd4,
      IX_SEL1 = 4'd5,
      IX_SEL2 = 4'd6,
      IX_SEL3 = 4'd7,
      IX_GATE = 4'd8,
      IX_SRST = 4'd9
   } reg_ix_e;

   // Byte offset of register i inside the bank window.
   function automatic logic [7:0] reg_off(input int i);
      case (i)
         0:       reg_off = 8'h00;
         1:       reg_off = 8'h04;
         2:       reg_off = 8'h08;
         3:       reg_off = 8'h20;
         4:       reg_off = 8'h30;
         5:       reg_off = 8'h34;
         6:       reg_off = 8'h38;
         7:       reg_off = 8'h3C;
         8:       reg_off = 8'h40;
         default: reg_off = 8'h50;
      endcase
   endfunction

   // Bits of register i that are not writable storage.
   function automatic logic [HALF_W-1:0] ro_mask(input int i);
      ro_mask = (i == 1) ? (HALF_W'(1) << LOCK_BIT) : '0;
   endfunction

endpackage

// File: rtl/hwm_addr_dec.sv
module hwm_addr_dec
   import hwm_pkg::*;
#(
   parameter int              ADDR_W = 24,
   parameter logic [ADDR_W-1:0] BASE = ADDR_W'(24'h140000)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  idx_o
);

   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_aw
      $error("hwm_addr_dec: ADDR_W must be 9..32");
   end
   if (BASE[7:0] != 8'h00) begin : g_bad_base
      $error("hwm_addr_dec: BASE must be 256-byte aligned");
   end

   logic in_window;
   assign in_window = (addr_i[ADDR_W-1:8] == BASE[ADDR_W-1:8]);

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < NREG; i++) begin
         if (in_window && addr_i[7:0] == reg_off(i)) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/hwm_mask_reg.sv
module hwm_mask_reg #(
   parameter int           W       = 16,
   parameter logic [W-1:0] RO_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [2*W-1:0] wdata_i,
   output logic [W-1:0] q_o
);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("hwm_mask_reg: W must be 1..16");
   end

   logic [W-1:0] bit_en;
   assign bit_en = we_i ? (wdata_i[2*W-1:W] & ~RO_MASK) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (q_o & ~bit_en) | (wdata_i[W-1:0] & bit_en);
   end

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
   // R2
   hold_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && wdata_i[2*W-1:W] == '0) |=> $stable(q_o));
   // R5
   ro_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ((q_o & RO_MASK) == '0));

endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
   import hwm_pkg::*;
#(
   parameter int              ADDR_W = 24,
   parameter logic [ADDR_W-1:0] BASE = ADDR_W'(24'h140000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              pll_lock_i,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic [15:0]       pll_ctl0_o,
   output logic              pll_pd_o,
   output logic [2:0]        pll_postdiv2_o,
   output logic [5:0]        pll_refdiv_o,
   output logic [15:0]       pll_ctl2_o,
   output logic [2:0]        pll_mode_o,
   output logic [4:0]        vclk4x_div_o,
   output logic [63:0]       clksel_o,
   output logic [15:0]       gate_o,
   output logic              srst_vid1x_o,
   output logic              srst_vid4x_o,
   output logic              srst_venc_bus_o,
   output logic              srst_regfile_o
);

   if (WORD_W != 32) begin : g_bad_word
      $error("hwm_ctrl_bank: bus word must be 32 bits");
   end

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic [HALF_W-1:0] q [NREG];

   hwm_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr_i (req_addr),
      .hit_o  (hit),
      .idx_o  (idx)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic we;
      assign we = req_valid && req_write && hit && (idx == IDX_W'(i));
      hwm_mask_reg #(.W(HALF_W), .RO_MASK(ro_mask(i))) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (we),
         .wdata_i (req_wdata),
         .q_o     (q[i])
      );
   end

   // Read view: stored bits plus the live lock flag on PLL control 1.
   logic [HALF_W-1:0] rd_half;
   always_comb begin
      rd_half = q[idx];
      if (idx == IX_PLL1) rd_half[LOCK_BIT] = pll_lock_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !hit;
         rsp_rdata <= (req_valid && !req_write && hit) ? {16'h0000, rd_half} : '0;
      end
   end

   assign pll_ctl0_o      = q[IX_PLL0];
   assign pll_pd_o        = q[IX_PLL1][13];
   assign pll_postdiv2_o  = q[IX_PLL1][8:6];
   assign pll_refdiv_o    = q[IX_PLL1][5:0];
   assign pll_ctl2_o      = q[IX_PLL2];
   assign pll_mode_o      = q[IX_MODE][2:0];
   assign vclk4x_div_o    = q[IX_SEL1][12:8];
   assign clksel_o        = {q[IX_SEL3], q[IX_SEL2], q[IX_SEL1], q[IX_SEL0]};
   assign gate_o          = q[IX_GATE];
   assign srst_vid1x_o    = q[IX_SRST][10];
   assign srst_vid4x_o    = q[IX_SRST][9];
   assign srst_venc_bus_o = q[IX_SRST][8];
   assign srst_regfile_o  = q[IX_SRST][3];

   // R3
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R9
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R3
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_rdata[31:16] == 16'h0000));
   // R4
   err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
   // R5
   lock_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == (BASE + ADDR_W'(4)))
      |=> (rsp_rdata[LOCK_BIT] == $past(pll_lock_i)));

endmodule

// File: tb/hwm_ctrl_bank_bench.sv
module hwm_ctrl_bank_bench;

   localparam int ADDR_W = 24;
   localparam logic [23:0] BASE = 24'h140000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, pll_lock_i = 1'b0;
   logic [23:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [15:0] pll_ctl0_o, pll_ctl2_o, gate_o;
   logic pll_pd_o, srst_vid1x_o, srst_vid4x_o, srst_venc_bus_o, srst_regfile_o;
   logic [2:0] pll_postdiv2_o, pll_mode_o;
   logic [5:0] pll_refdiv_o;
   logic [4:0] vclk4x_div_o;
   logic [63:0] clksel_o;

   always #10 clk = ~clk;

   hwm_ctrl_bank #(.ADDR_W(ADDR_W), .BASE(BASE)) u_hwm_ctrl_bank (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .pll_lock_i,
      .rsp_valid, .rsp_rdata, .rsp_err, .pll_ctl0_o, .pll_pd_o, .pll_postdiv2_o,
      .pll_refdiv_o, .pll_ctl2_o, .pll_mode_o, .vclk4x_div_o, .clksel_o, .gate_o,
      .srst_vid1x_o, .srst_vid4x_o, .srst_venc_bus_o, .srst_regfile_o
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int unsigned model [10];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int off_to_idx(input logic [23:0] a);
      if (a[23:8] != BASE[23:8]) return -1;
      case (a[7:0])
         8'h00: return 0; 8'h04: return 1; 8'h08: return 2; 8'h20: return 3;
         8'h30: return 4; 8'h34: return 5; 8'h38: return 6; 8'h3C: return 7;
         8'h40: return 8; 8'h50: return 9;
         default: return -1;
      endcase
   endfunction

   task automatic chk_fields();
      chk("R6 ctl0", 64'(pll_ctl0_o), 64'(model[0] & 16'hFFFF));
      chk("R6 pd", 64'(pll_pd_o), 64'((model[1] >> 13) & 1));
      chk("R6 postdiv2", 64'(pll_postdiv2_o), 64'((model[1] >> 6) & 7));
      chk("R6 refdiv", 64'(pll_refdiv_o), 64'(model[1] & 63));
      chk("R6 ctl2", 64'(pll_ctl2_o), 64'(model[2] & 16'hFFFF));
      chk("R8 mode", 64'(pll_mode_o), 64'(model[3] & 7));
      chk("R8 div4x", 64'(vclk4x_div_o), 64'((model[5] >> 8) & 31));
      chk("R8 clksel", clksel_o, {model[7][15:0], model[6][15:0], model[5][15:0], model[4][15:0]});
      chk("R8 gate", 64'(gate_o), 64'(model[8] & 16'hFFFF));
      chk("R7 vid1x", 64'(srst_vid1x_o), 64'((model[9] >> 10) & 1));
      chk("R7 vid4x", 64'(srst_vid4x_o), 64'((model[9] >> 9) & 1));
      chk("R7 venc", 64'(srst_venc_bus_o), 64'((model[9] >> 8) & 1));
      chk("R7 regfile", 64'(srst_regfile_o), 64'((model[9] >> 3) & 1));
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic acc(input bit wr, input logic [23:0] a, input logic [31:0] d, input bit lock);
      int ix;
      logic [31:0] exp_rd;
      bit exp_err;
      int unsigned en;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; pll_lock_i = lock;
      @(posedge clk);
      ix = off_to_idx(a);
      exp_err = (ix < 0);
      exp_rd = 32'h0;
      if (!wr && ix >= 0) begin
         exp_rd = model[ix] & 32'hFFFF;
         if (ix == 1) exp_rd[10] = lock;
      end
      if (wr && ix >= 0) begin
         en = d >> 16;
         if (ix == 1) en = en & ~32'h400;
         model[ix] = (model[ix] & ~en) | (d & en & 32'hFFFF);
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 valid", 64'(rsp_valid), 64'd1);
      chk("R4 err", 64'(rsp_err), 64'(exp_err));
      chk("R3 rdata", 64'(rsp_rdata), 64'(exp_rd));
      chk_fields();
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
      chk("R9 idle valid", 64'(rsp_valid), 64'd0);
      chk_fields();
   endtask

   task automatic rd(input logic [7:0] off, input bit lock);
      acc(1'b0, BASE + 24'(off), 32'h0, lock);
   endtask

   task automatic wr(input logic [7:0] off, input logic [31:0] d);
      acc(1'b1, BASE + 24'(off), d, 1'b0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 10; i++) model[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 valid", 64'(rsp_valid), 64'd0);
      chk_fields();
      foreach (model[i]) rd(hwm_pkg::reg_off(i), 1'b0);

      // R5: write all ones into PLL control 1; lock bit stays a live view
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, 1'b0);
      rd(8'h04, 1'b1);
      wr(8'h04, 32'h0400_0000);
      rd(8'h04, 1'b1);

      // R2: partial masks
      wr(8'h34, 32'h00F0_1234);
      rd(8'h34, 1'b0);
      wr(8'h34, 32'h1F00_0A00);
      wr(8'h34, 32'h0000_FFFF);
      rd(8'h34, 1'b0);
      wr(8'h04, 32'h2000_0000);
      wr(8'h04, 32'h01C0_0080);
      rd(8'h04, 1'b0);

      // R7 / R8 fields
      wr(8'h50, 32'h0708_0508);
      wr(8'h20, 32'h0007_0005);
      wr(8'h30, 32'hFFFF_A5A5);
      wr(8'h38, 32'h0F0F_1234);
      wr(8'h3C, 32'h8001_FFFF);
      wr(8'h40, 32'hFFFF_C3C3);
      wr(8'h00, 32'hFF00_ABCD);
      wr(8'h08, 32'h00FF_ABCD);
      wr(8'h50, 32'h0400_0000);
      foreach (model[i]) rd(hwm_pkg::reg_off(i), 1'b1);

      // R4: holes, misaligned, outside window; no state change
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h54, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      rd(8'h0C, 1'b0);
      rd(8'hFC, 1'b0);
      acc(1'b1, 24'h040000, 32'hFFFF_FFFF, 1'b0);
      acc(1'b0, 24'h140100, 32'h0, 1'b0);

      // R9 idle cycles
      idle();
      idle();
      foreach (model[i]) rd(hwm_pkg::reg_off(i), 1'b0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule